// File: doc/BRIEF.md
# Asynchronous Static RAM Port Controller

This block lets a clocked subsystem read and write an external asynchronous static RAM of 32K bytes. On the user side it takes one request at a time: a valid strobe, a write flag, a 15-bit byte address and 8 bits of write data. It answers with a one-cycle ready pulse and, for reads, the captured byte. On the memory side it drives active-low chip select, write enable and output enable, the address bus, and a split data bus. The split bus has an output value, a drive enable for the pad tri-state, and an input value.

All memory timing is given as durations in picoseconds, plus the recovery delay in nanoseconds. Each duration becomes a whole number of clock cycles, rounded up. The controller walks every access through fixed phases. Each phase is timed by a down-counter. The address only moves at the start of an access, while write enable is high. After a read, the data bus is left alone until the memory has had time to release it.

A retention input parks the memory deselected for low-power data retention. After it is dropped, the controller waits a long recovery interval before the next access may begin.

Top module: `sram_port_ctrl`

## Requirements
- R1: During and after reset, with no request, chip select, write enable and output enable are all high, the drive enable is low and ready is low.
- R2: Strobe encoding: idle and released phases have chip select high. A read has chip select low, output enable low and write enable high. A write has chip select low, write enable low and output enable high. Write enable and output enable are never low together.
- R3: A write asserts chip select one cycle before write enable falls. Write enable then stays low for the larger of ceil(55 ns / Tclk) and ceil(30 ns / Tclk) cycles, which is 14 at 4 ns. The data bus is driven with stable data throughout that pulse. After the pulse come tail cycles with all strobes high, enough to make the write at least ceil(70 ns / Tclk) = 18 cycles. Ready rises in the cycle after these 18 cycles.
- R4: The address never changes while chip select is low, so in particular never while chip select and write enable are both low.
- R5: A read holds its strobes for the larger of the 70 ns address access, the 35 ns output-enable access and the 70 ns read cycle, in cycles (18 at 4 ns). The data bus input is captured on the last of those cycles. It appears on the read-data output together with ready.
- R6: The drive enable is never high while output enable is low. After a read, output enable stays high for at least ceil(30 ns / Tclk) = 8 cycles before the bus may be driven. During those cycles the controller is not idle, and ready rises in the cycle after them.
- R7: Ready is high for exactly one cycle per completed request. A request is taken only while the controller is idle.
- R8: While the retention input is high, chip select stays high and no request is taken. After the input falls, no access starts for at least ceil(recovery / Tclk) cycles. Stored data is still readable afterwards.
- R9: If the retention input and a request are both present in the same idle cycle, retention is entered first. The request is served only after the recovery wait.
- R10: A read returns the byte most recently written to the same address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; held until the access starts |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 15 | Byte address |
| req_wdata | input | 8 | Write data |
| retain_req | input | 1 | Level request for deselected data retention |
| req_ready | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Byte captured by the last read |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_addr | output | 15 | Memory address bus |
| mem_dq_oe | output | 1 | Drive enable for the data pads |
| mem_dq_out | output | 8 | Data driven toward the memory |
| mem_dq_in | input | 8 | Data received from the memory |

## Verification
In the idle state a new request and a retention request can arrive in the same cycle, and the controller must pick one of them. The bench raises both on the same edge, holds both, and watches chip select. Chip select must stay high for the whole retention hold and for at least the recovery count after retention is released. The pending write must then run and be read back intact. A second overlap checks the bus turnaround: a write is issued right after a read completes. The bench then measures how many cycles output enable was high before the drive enable rose.

// File: rtl/sram_port_pkg.sv
package sram_port_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WSETUP,
        ST_WPULSE,
        ST_WTAIL,
        ST_RACCESS,
        ST_RRELEASE,
        ST_RETAIN,
        ST_RECOVER
    } ctrl_state_e;

    // duration in ps -> whole clock cycles, rounded up
    function automatic int unsigned cyc_ceil(longint unsigned dur_ps, longint unsigned clk_ps);
        return int'((dur_ps + clk_ps - 64'd1) / clk_ps);
    endfunction

    function automatic int unsigned max_u(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_cyc_timer.sv
module sram_cyc_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = load_val_i;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);

    // phase lengths in R3/R5 rely on one step per cycle
    assert_timer_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_i,
    input  logic [DW-1:0] din_i,
    output logic [DW-1:0] dout_o
);
    logic [DW-1:0] data_d, data_q;

    always_comb begin
        data_d = data_q;
        if (cap_i) data_d = din_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) data_q <= '0;
        else        data_q <= data_d;
    end

    assign dout_o = data_q;

    assert_capture_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_i |=> $stable(dout_o));

endmodule

// File: rtl/sram_port_ctrl.sv
module sram_port_ctrl
    import sram_port_pkg::*;
#(
    parameter int              AW         = 15,
    parameter int              DW         = 8,
    parameter int              CLK_PS     = 4000,
    parameter int              T_WP_PS    = 55000,
    parameter int              T_DSU_PS   = 30000,
    parameter int              T_WC_PS    = 70000,
    parameter int              T_AA_PS    = 70000,
    parameter int              T_OEA_PS   = 35000,
    parameter int              T_RC_PS    = 70000,
    parameter int              T_HZ_PS    = 30000,
    parameter longint unsigned RECOVER_NS = 64'd5000000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic          retain_req,
    output logic          req_ready,
    output logic [DW-1:0] rsp_rdata,
    output logic          mem_cs_n,
    output logic          mem_we_n,
    output logic          mem_oe_n,
    output logic [AW-1:0] mem_addr,
    output logic          mem_dq_oe,
    output logic [DW-1:0] mem_dq_out,
    input  logic [DW-1:0] mem_dq_in
);
    localparam longint unsigned CLK_L = longint'(CLK_PS);
    localparam int unsigned N_WP  = max_u(max_u(cyc_ceil(longint'(T_WP_PS), CLK_L),
                                                cyc_ceil(longint'(T_DSU_PS), CLK_L)), 1);
    localparam int unsigned N_WC  = cyc_ceil(longint'(T_WC_PS), CLK_L);
    localparam int unsigned N_WT  = (N_WC > N_WP + 1) ? (N_WC - N_WP - 1) : 1;
    localparam int unsigned N_RD  = max_u(max_u(cyc_ceil(longint'(T_AA_PS), CLK_L),
                                                cyc_ceil(longint'(T_OEA_PS), CLK_L)),
                                          max_u(cyc_ceil(longint'(T_RC_PS), CLK_L), 1));
    localparam int unsigned N_HZ  = max_u(cyc_ceil(longint'(T_HZ_PS), CLK_L), 1);
    localparam int unsigned N_REC = max_u(cyc_ceil(RECOVER_NS * 64'd1000, CLK_L), 1);
    localparam int unsigned N_TOP = max_u(max_u(max_u(N_WP, N_WT), max_u(N_RD, N_HZ)), N_REC);
    localparam int          CNT_W = $clog2(N_TOP + 1);

    localparam logic [CNT_W-1:0] LD_WP  = CNT_W'(N_WP - 1);
    localparam logic [CNT_W-1:0] LD_WT  = CNT_W'(N_WT - 1);
    localparam logic [CNT_W-1:0] LD_RD  = CNT_W'(N_RD - 1);
    localparam logic [CNT_W-1:0] LD_HZ  = CNT_W'(N_HZ - 1);
    localparam logic [CNT_W-1:0] LD_REC = CNT_W'(N_REC - 1);

    typedef struct packed {
        ctrl_state_e   st;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic          cs_n;
        logic          we_n;
        logic          oe_n;
        logic          dq_oe;
        logic          ready;
    } ctrl_t;

    ctrl_t             ctl_d, ctl_q;
    logic              tm_load, tm_zero, cap_en;
    logic [CNT_W-1:0]  tm_val;

    sram_cyc_timer #(.W(CNT_W)) i_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tm_load),
        .load_val_i (tm_val),
        .zero_o     (tm_zero)
    );

    sram_rd_capture #(.DW(DW)) i_capture (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_i  (cap_en),
        .din_i  (mem_dq_in),
        .dout_o (rsp_rdata)
    );

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.ready = 1'b0;
        tm_load     = 1'b0;
        tm_val      = '0;
        cap_en      = 1'b0;
        case (ctl_q.st)
            ST_IDLE: begin
                if (retain_req) begin
                    ctl_d.st = ST_RETAIN;              // retention wins over a request
                end else if (req_valid) begin
                    ctl_d.addr  = req_addr;            // only place the address moves
                    ctl_d.wdata = req_wdata;
                    if (req_write) begin
                        ctl_d.st = ST_WSETUP;
                    end else begin
                        ctl_d.st = ST_RACCESS;
                        tm_load  = 1'b1;
                        tm_val   = LD_RD;
                    end
                end
            end
            ST_WSETUP: begin
                ctl_d.st = ST_WPULSE;
                tm_load  = 1'b1;
                tm_val   = LD_WP;
            end
            ST_WPULSE: if (tm_zero) begin
                ctl_d.st = ST_WTAIL;
                tm_load  = 1'b1;
                tm_val   = LD_WT;
            end
            ST_WTAIL: if (tm_zero) begin
                ctl_d.st    = ST_IDLE;
                ctl_d.ready = 1'b1;
            end
            ST_RACCESS: if (tm_zero) begin
                cap_en   = 1'b1;
                ctl_d.st = ST_RRELEASE;
                tm_load  = 1'b1;
                tm_val   = LD_HZ;
            end
            ST_RRELEASE: if (tm_zero) begin
                ctl_d.st    = ST_IDLE;
                ctl_d.ready = 1'b1;
            end
            ST_RETAIN: if (!retain_req) begin
                ctl_d.st = ST_RECOVER;
                tm_load  = 1'b1;
                tm_val   = LD_REC;
            end
            ST_RECOVER: if (tm_zero) begin
                ctl_d.st = ST_IDLE;
            end
            default: ctl_d.st = ST_IDLE;
        endcase

        // registered strobes follow the next phase
        ctl_d.cs_n  = !(ctl_d.st inside {ST_WSETUP, ST_WPULSE, ST_RACCESS});
        ctl_d.we_n  = (ctl_d.st != ST_WPULSE);
        ctl_d.oe_n  = (ctl_d.st != ST_RACCESS);
        ctl_d.dq_oe = (ctl_d.st inside {ST_WPULSE, ST_WTAIL});
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.st    <= ST_IDLE;
            ctl_q.cs_n  <= 1'b1;
            ctl_q.we_n  <= 1'b1;
            ctl_q.oe_n  <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign req_ready  = ctl_q.ready;
    assign mem_cs_n   = ctl_q.cs_n;
    assign mem_we_n   = ctl_q.we_n;
    assign mem_oe_n   = ctl_q.oe_n;
    assign mem_addr   = ctl_q.addr;
    assign mem_dq_oe  = ctl_q.dq_oe;
    assign mem_dq_out = ctl_q.wdata;

    // write-pulse length watcher for R3
    logic [CNT_W-1:0] we_low_q;
    always_ff @(posedge clk) begin
        if (!rst_n)         we_low_q <= '0;
        else if (!mem_we_n) we_low_q <= we_low_q + 1'b1;
        else                we_low_q <= '0;
    end

    assert_pulse_min_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (we_low_q >= CNT_W'(N_WP)));

    assert_strobe_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (mem_oe_n && !mem_cs_n));

    assert_addr_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && !$past(mem_cs_n)) |-> $stable(mem_addr));

    assert_no_contention_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);

    assert_ready_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> !req_ready);

    assert_retain_deselect_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st inside {ST_RETAIN, ST_RECOVER}) |-> (mem_cs_n && !mem_dq_oe));

endmodule

// File: tb/test_sram_port_ctrl.sv
`timescale 1ns/1ps
module test_sram_port_ctrl;

    localparam int N_WP  = 14;   // ceil(55/4)
    localparam int N_RD  = 18;   // ceil(70/4)
    localparam int N_HZ  = 8;    // ceil(30/4)
    localparam int N_REC = 100;  // ceil(400 ns/4)

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, retain_req = 1'b0;
    logic [14:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [7:0]  rsp_rdata, mem_dq_out;
    logic [7:0]  mem_dq_in = 8'hEE;
    logic [14:0] mem_addr;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sram_port_ctrl #(.RECOVER_NS(64'd400)) i_sram_port_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .retain_req(retain_req),
        .req_ready(req_ready), .rsp_rdata(rsp_rdata), .mem_cs_n(mem_cs_n),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_addr(mem_addr),
        .mem_dq_oe(mem_dq_oe), .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in)
    );

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // memory model and bus monitor, sampled away from the active edge
    logic [7:0]  model_mem [int];
    int          we_run = 0, oe_run = 0, hz_age = 1000, rd_age = 0;
    logic        prev_cs_n = 1'b1, prev_we_n = 1'b1, prev_dq_oe = 1'b0;
    logic [14:0] prev_addr = '0;
    logic [7:0]  prev_dout = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_dq_oe && !prev_dq_oe)
                check(mem_oe_n && hz_age >= N_HZ, "R6", "released cycles before drive", hz_age, N_HZ);
            if (!mem_cs_n && !prev_cs_n && mem_addr != prev_addr)
                check(0, "R4", "address moved under chip select", mem_addr, prev_addr);
            if (!mem_we_n) begin
                if (!prev_we_n)
                    check(mem_dq_out == prev_dout && mem_dq_oe, "R3", "data stable in pulse", mem_dq_out, prev_dout);
                we_run++;
            end else if (!prev_we_n) begin
                check(we_run == N_WP, "R3", "write pulse cycles", we_run, N_WP);
                we_run = 0;
            end
            if (!mem_oe_n) begin
                if (!(mem_we_n && !mem_cs_n))
                    check(0, "R2", "read strobe encoding", {mem_cs_n, mem_we_n}, 2'b01);
                oe_run++;
            end else if (oe_run != 0) begin
                check(oe_run == N_RD, "R5", "read strobe cycles", oe_run, N_RD);
                oe_run = 0;
            end
            if (!mem_oe_n) hz_age = 0;
            else if (hz_age < 1000) hz_age++;
            // memory behaviour
            if (!mem_cs_n && !mem_we_n && mem_dq_oe) model_mem[int'(mem_addr)] = mem_dq_out;
            if (!mem_cs_n && !mem_oe_n && mem_we_n) begin
                if (rd_age >= N_RD - 1)
                    mem_dq_in = model_mem.exists(int'(mem_addr)) ? model_mem[int'(mem_addr)] : ~mem_addr[7:0];
                else
                    mem_dq_in = 8'hEE;
                rd_age++;
            end else begin
                rd_age = 0;
                mem_dq_in = 8'hEE;
            end
        end
        prev_cs_n  = mem_cs_n;
        prev_we_n  = mem_we_n;
        prev_dq_oe = mem_dq_oe;
        prev_addr  = mem_addr;
        prev_dout  = mem_dq_out;
    end

    // issue one request; returns read byte and cycles from first strobe to ready
    task automatic do_req(bit wr, logic [14:0] a, logic [7:0] d, output logic [7:0] rd, output int span);
        int t;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        t = 0;
        do begin @(negedge clk); t++; end while (mem_cs_n && t < 5000);
        req_valid = 1'b0;
        span = 1;
        while (!req_ready && span < 5000) begin @(negedge clk); span++; end
        rd = rsp_rdata;
        @(negedge clk);
        check(!req_ready, "R7", "ready one cycle", req_ready, 0);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check(mem_cs_n && mem_we_n && mem_oe_n, "R1", "strobes high in reset",
              {mem_cs_n, mem_we_n, mem_oe_n}, 3'b111);
        check(!mem_dq_oe && !req_ready, "R1", "bus and ready low in reset", {mem_dq_oe, req_ready}, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe, "R1", "idle after reset",
              {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b1110);
    endtask

    task automatic t_write_read();
        logic [7:0] rd; int span;
        logic [14:0] addrs [3] = '{15'h0000, 15'h7FFF, 15'h1234};
        logic [7:0]  vals  [3] = '{8'hA5, 8'h3C, 8'h00};
        for (int i = 0; i < 3; i++) begin
            do_req(1'b1, addrs[i], vals[i], rd, span);
            check(span == 19, "R3", "write span to ready", span, 19);
        end
        for (int i = 0; i < 3; i++) begin
            do_req(1'b0, addrs[i], 8'h00, rd, span);
            check(span == N_RD + N_HZ + 1, "R5", "read span to ready", span, N_RD + N_HZ + 1);
            check(rd == vals[i], "R10", "read back", rd, vals[i]);
        end
    endtask

    task automatic t_unwritten_and_overwrite();
        logic [7:0] rd; int span;
        do_req(1'b0, 15'h0055, 8'h00, rd, span);
        check(rd == 8'hAA, "R5", "captured last access cycle", rd, 8'hAA);
        do_req(1'b1, 15'h0100, 8'h11, rd, span);
        do_req(1'b1, 15'h0100, 8'hF0, rd, span);
        do_req(1'b0, 15'h0100, 8'h00, rd, span);
        check(rd == 8'hF0, "R10", "latest write wins", rd, 8'hF0);
    endtask

    task automatic t_turnaround();
        logic [7:0] rd; int span;
        do_req(1'b0, 15'h7FFF, 8'h00, rd, span);
        check(rd == 8'h3C, "R6", "read before turnaround", rd, 8'h3C);
        do_req(1'b1, 15'h2222, 8'h5A, rd, span);     // drive-enable gap checked by monitor
        do_req(1'b0, 15'h2222, 8'h00, rd, span);
        check(rd == 8'h5A, "R6", "write after read lands", rd, 8'h5A);
    endtask

    task automatic t_retention();
        int t, cs_low; logic [7:0] rd; int span;
        @(negedge clk);
        retain_req = 1'b1;                            // same cycle as request: R9
        req_valid = 1'b1; req_write = 1'b1; req_addr = 15'h0777; req_wdata = 8'h99;
        cs_low = 0;
        repeat (30) begin @(negedge clk); if (!mem_cs_n) cs_low++; end
        check(cs_low == 0, "R9", "request blocked by retention", cs_low, 0);
        check(!req_ready, "R8", "no completion in retention", req_ready, 0);
        retain_req = 1'b0;
        t = 0;
        do begin @(negedge clk); t++; end while (mem_cs_n && t < 5000);
        req_valid = 1'b0;
        check(t >= N_REC + 1 && t <= N_REC + 4, "R8", "recovery wait cycles", t, N_REC + 2);
        while (!req_ready) @(negedge clk);
        do_req(1'b0, 15'h0777, 8'h00, rd, span);
        check(rd == 8'h99, "R9", "deferred write served", rd, 8'h99);
        do_req(1'b0, 15'h0000, 8'h00, rd, span);
        check(rd == 8'hA5, "R8", "data kept across retention", rd, 8'hA5);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_write_read();
        t_unwritten_and_overwrite();
        t_turnaround();
        t_retention();
        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule